// File: doc/BRIEF.md
# Text Buffer to Byte Stream Sequencer

This block keeps a text buffer of ten 16-byte blocks that software fills one 32-bit word at a time through a plain write port. Each block is four words, the word at the lowest address holding the least significant 32 bits of the block. Software places the leftmost byte of its message in the top byte of block 0. The message is associated data followed by plain or cipher text, zero-padded on the right to a whole block.

Software also writes a byte length and then a start command. The block then sends blocks 0, 1, 2, ... as beats of a 128-bit stream packet. Each block is byte-reversed on the way out, so the most significant byte of the block leaves in stream byte lane 0. The final beat carries an empty-byte count that marks the trailing pad bytes. While a packet is in flight the buffer, the length and the start command are locked. A length outside the legal range raises an error flag and sends nothing.

Top module: `txs_top`

## Requirements
- R1: After reset, `m_tvalid`, `busy` and `err` are low and the length register is 0.
- R2: Word address `4*b + w` (block b in 0..9, word w in 0..3) holds bits `[32*w+31:32*w]` of block b. Address 40 holds the byte length in `wr_data[7:0]`. A write to address 41 with `wr_data[0]=1` is a start command.
- R3: Beat i of a packet carries block i. Its stream byte lane k (`m_tdata[8k+7:8k]`) holds byte 15-k of that block, so the block's top byte goes first.
- R4: A packet of length L has ceil(L/16) beats. `m_tlast` is high on the final beat only.
- R5: While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata`, `m_tlast` and `m_tempty` hold their values.
- R6: `m_tempty` equals 16*ceil(L/16) - L on the final beat (range 0..15) and is 0 on every other beat.
- R7: A start with a legal length while idle makes `busy` and `m_tvalid` high at the next edge and clears `err`. `busy` drops at the edge that completes the final handshake.
- R8: A start command while busy is ignored: no extra beats or packets follow.
- R9: Writes to the text words or to the length register while busy are ignored.
- R10: A start while idle with length 0 or above 160 sets `err`, leaves `busy` low and sends no beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Word address of the write |
| wr_data | input | 32 | Write data |
| m_tvalid | output | 1 | Stream beat valid |
| m_tready | input | 1 | Stream consumer ready |
| m_tdata | output | 128 | Stream beat data, lane 0 sent first |
| m_tlast | output | 1 | Final beat of the packet |
| m_tempty | output | 4 | Count of trailing pad bytes on the final beat |
| busy | output | 1 | Packet in flight |
| err | output | 1 | Last start had an illegal length |

## Verification
The assertions assume that `m_tready` is a plain level from the consumer and may toggle freely. They also assume that software may write any address at any time, busy or not. The bench relies on this by driving `m_tready` from a pseudo-random pattern with stalls of several cycles. It also issues starts and writes to the text and length registers on purpose during a packet. Lengths cover one byte, exact block multiples, partial last blocks, the full 160 bytes and both illegal ends. A queue of expected beats is checked against every handshake, so a stray beat after a rejected start is caught as well.

// File: rtl/txs_pkg.sv
package txs_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } txs_state_e;
endpackage

// File: rtl/txs_regfile.sv
module txs_regfile #(
  parameter int NUM_BLK   = 10,
  parameter int WPB       = 4,
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 6,
  parameter int IDX_W     = 4,
  localparam int NUM_W    = NUM_BLK * WPB,
  localparam int BLK_W    = WPB * WORD_W,
  localparam int BLK_BYTES = BLK_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BLK_W-1:0]  rd_swapped
);
  logic [WORD_W-1:0] mem_q [NUM_W];
  logic [WORD_W-1:0] mem_d [NUM_W];
  logic [BLK_W-1:0]  blk;

  always_comb begin
    for (int i = 0; i < NUM_W; i++) mem_d[i] = mem_q[i];
    if (we && (waddr < ADDR_W'(NUM_W))) mem_d[waddr] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_W; i++) mem_q[i] <= '0;
    end else if (we) begin
      for (int i = 0; i < NUM_W; i++) mem_q[i] <= mem_d[i];
    end
  end

  // gather the selected block, word 0 in the low bits
  always_comb begin
    for (int w = 0; w < WPB; w++) begin
      logic [ADDR_W-1:0] sel;
      sel = ADDR_W'(rd_idx) * ADDR_W'(WPB) + ADDR_W'(w);
      blk[w*WORD_W +: WORD_W] = mem_q[sel];
    end
  end

  // byte reversal: top byte of the block lands in lane 0
  for (genvar k = 0; k < BLK_BYTES; k++) begin : g_swap
    assign rd_swapped[8*k +: 8] = blk[8*(BLK_BYTES-1-k) +: 8];
  end
endmodule

// File: rtl/txs_ctrl.sv
module txs_ctrl
  import txs_pkg::*;
#(
  parameter int NUM_BLK   = 10,
  parameter int BLK_BYTES = 16,
  parameter int LEN_W     = 8,
  parameter int IDX_W     = 4,
  parameter int EMP_W     = 4,
  localparam int MAX_LEN  = NUM_BLK * BLK_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic             tready,
  output logic             tvalid,
  output logic             tlast,
  output logic [EMP_W-1:0] tempty,
  output logic [IDX_W-1:0] idx,
  output logic             busy,
  output logic             err
);
  txs_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d, last_q, last_d;
  logic [EMP_W-1:0] emp_q, emp_d;
  logic             err_q, err_d;
  logic             len_ok, hs, at_last;
  logic [LEN_W-1:0] len_m1;
  logic [LEN_W:0]   emp_full;

  assign len_ok   = (len != '0) && ({1'b0, len} <= (LEN_W+1)'(MAX_LEN));
  assign len_m1   = len - LEN_W'(1);
  assign emp_full = (LEN_W+1)'(BLK_BYTES) - (LEN_W+1)'(len[EMP_W-1:0]);
  assign at_last  = (idx_q == last_q);
  assign hs       = (state_q == ST_SEND) && tready;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    last_d  = last_q;
    emp_d   = emp_q;
    err_d   = err_q;
    if (state_q == ST_IDLE) begin
      if (start) begin
        err_d = !len_ok;
        if (len_ok) begin
          state_d = ST_SEND;
          idx_d   = '0;
          last_d  = IDX_W'(len_m1 >> EMP_W);
          emp_d   = emp_full[EMP_W-1:0];
        end
      end
    end else if (hs) begin
      if (at_last) state_d = ST_IDLE;
      else         idx_d   = idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
      emp_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      last_q  <= last_d;
      emp_q   <= emp_d;
      err_q   <= err_d;
    end
  end

  assign busy   = (state_q == ST_SEND);
  assign tvalid = busy;
  assign tlast  = busy && at_last;
  assign tempty = tlast ? emp_q : '0;
  assign idx    = idx_q;
  assign err    = err_q;

  a_r4_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx_q <= last_q) && (last_q < IDX_W'(NUM_BLK)));
  a_r5_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tvalid && !tready) |=> tvalid && $stable(tlast) && $stable(tempty));
  a_r6_empty_off_last: assert property (@(posedge clk) disable iff (!rst_n)
    !tlast |-> (tempty == '0));
  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (tvalid && tready && tlast) |=> !busy);
  a_r10_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !tvalid);
endmodule

// File: rtl/txs_top.sv
module txs_top #(
  parameter int NUM_BLK   = 10,
  parameter int BLK_BYTES = 16,
  parameter int WORD_W    = 32,
  localparam int WPB      = BLK_BYTES / (WORD_W / 8),
  localparam int NUM_W    = NUM_BLK * WPB,
  localparam int ADDR_W   = $clog2(NUM_W + 2),
  localparam int LEN_W    = $clog2(NUM_BLK * BLK_BYTES + 1),
  localparam int IDX_W    = $clog2(NUM_BLK),
  localparam int EMP_W    = $clog2(BLK_BYTES),
  localparam int DATA_W   = BLK_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic [DATA_W-1:0] m_tdata,
  output logic              m_tlast,
  output logic [EMP_W-1:0]  m_tempty,
  output logic              busy,
  output logic              err
);
  localparam logic [ADDR_W-1:0] ADDR_LEN  = ADDR_W'(NUM_W);
  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(NUM_W + 1);

  logic             wr_ok, start, len_we;
  logic [LEN_W-1:0] len_q, len_d;
  logic [IDX_W-1:0] idx;

  assign wr_ok  = wr_en && !busy;
  assign len_we = wr_ok && (wr_addr == ADDR_LEN);
  assign start  = wr_ok && (wr_addr == ADDR_CTRL) && wr_data[0];

  always_comb begin
    len_d = len_q;
    if (len_we) len_d = wr_data[LEN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (len_we) len_q <= len_d;
  end

  txs_regfile #(
    .NUM_BLK(NUM_BLK), .WPB(WPB), .WORD_W(WORD_W),
    .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(wr_ok), .waddr(wr_addr),
    .wdata(wr_data), .rd_idx(idx), .rd_swapped(m_tdata)
  );

  txs_ctrl #(
    .NUM_BLK(NUM_BLK), .BLK_BYTES(BLK_BYTES), .LEN_W(LEN_W),
    .IDX_W(IDX_W), .EMP_W(EMP_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .len(len_q),
    .tready(m_tready), .tvalid(m_tvalid), .tlast(m_tlast),
    .tempty(m_tempty), .idx(idx), .busy(busy), .err(err)
  );

  a_r5_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> $stable(m_tdata));
  a_r9_len_locked: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(len_q));
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(m_tready && m_tlast)) |=> busy);
endmodule

// File: tb/txs_top_bench.sv
module txs_top_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [5:0]   wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic         m_tvalid, m_tready, m_tlast, busy, err;
  logic [127:0] m_tdata;
  logic [3:0]   m_tempty;

  int tests = 0, fails = 0, cyc = 0;
  logic [7:0]   msg [160];
  logic [132:0] expq [$];
  logic [7:0]   lfsr = 8'hA5;
  bit           rdy_always = 1'b0;
  bit           done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  txs_top u_txs_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .m_tvalid(m_tvalid), .m_tready(m_tready),
    .m_tdata(m_tdata), .m_tlast(m_tlast), .m_tempty(m_tempty),
    .busy(busy), .err(err)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor + ready driver, away from the active edge
  initial m_tready = 1'b0;
  always @(negedge clk) begin
    if (rst_n && m_tvalid && m_tready) begin
      if (expq.size() == 0) chk(1'b0, "R4/R8/R10 unexpected beat", m_tdata, 0);
      else begin
        logic [132:0] e;
        e = expq.pop_front();
        chk(m_tdata == e[132:5], "R3 beat data", m_tdata, e[132:5]);
        chk(m_tlast == e[4], "R4 tlast", m_tlast, e[4]);
        chk(m_tempty == e[3:0], "R6 tempty", m_tempty, e[3:0]);
      end
    end
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    m_tready <= rdy_always ? 1'b1 : (lfsr[0] | lfsr[2]);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 6'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(input int len, input int seed);
    for (int i = 0; i < 160; i++) msg[i] = (i < len) ? 8'(seed * 7 + i * 13 + 1) : 8'h00;
    for (int b = 0; b < (len + 15) / 16; b++)
      for (int w = 0; w < 4; w++)
        wr(4 * b + w, {msg[16*b+12-4*w], msg[16*b+13-4*w], msg[16*b+14-4*w], msg[16*b+15-4*w]});
  endtask

  task automatic push_exp(input int len);
    int beats;
    beats = (len + 15) / 16;
    for (int i = 0; i < beats; i++) begin
      logic [127:0] d;
      bit last;
      for (int k = 0; k < 16; k++) d[8*k +: 8] = msg[16*i+k];
      last = (i == beats - 1);
      expq.push_back({d, last, last ? 4'(16 * beats - len) : 4'd0});
    end
  endtask

  task automatic wait_done();
    while (busy) @(negedge clk);
    chk(expq.size() == 0, "R4 beat count", expq.size(), 0);
    chk(!busy && !m_tvalid, "R7 busy clears", busy, 0);
  endtask

  task automatic send(input int len, input int seed);
    load(len, seed);
    push_exp(len);
    wr(40, 32'(len));
    wr(41, 32'h1);
    chk(busy && m_tvalid && !err, "R7 start sets busy", {busy, m_tvalid, err}, 3'b110);
    wait_done();
  endtask

  task automatic bad_len(input int len);
    wr(40, 32'(len));
    wr(41, 32'h1);
    chk(err && !busy && !m_tvalid, "R10 illegal length", {err, busy, m_tvalid}, 3'b100);
    repeat (10) @(negedge clk);
    chk(!m_tvalid, "R10 nothing sent", m_tvalid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!m_tvalid && !busy && !err, "R1 reset state", {m_tvalid, busy, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!m_tvalid && !busy && !err, "R1 after release", {m_tvalid, busy, err}, 0);
    // R2 R3 R4 R6 across lengths
    send(16, 1);
    send(1, 2);
    send(37, 3);
    send(17, 4);
    rdy_always = 1'b1;
    send(32, 5);
    rdy_always = 1'b0;
    // R8 R9: locked during a full packet
    load(160, 6);
    push_exp(160);
    wr(40, 160);
    wr(41, 1);
    wr(41, 1);
    wr(0, 32'hDEADBEEF);
    wr(40, 5);
    wait_done();
    repeat (20) @(negedge clk);
    chk(!m_tvalid && expq.size() == 0, "R8 no restart", m_tvalid, 0);
    push_exp(160);
    wr(41, 1);
    wait_done();
    // R10 then recovery (R7 clears err)
    bad_len(0);
    bad_len(161);
    bad_len(255);
    send(100, 7);
    chk(!err, "R7 err cleared", err, 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule